// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital controller of a three-phase integrating analog-to-digital converter. It divides a fast oscillator clock into a system tick. It then steps through a fixed frame of system counts. The frame holds an auto-zero phase, a fixed-length signal integrate phase, and a reference deintegrate phase. The deintegrate phase ends at the first comparator zero crossing. One of four analog switch enables is driven at all times. Deintegrate time left unused after the crossing is given to the auto-zero phase that follows, so every frame has the same length whatever the input.

The deintegrate direction comes from a polarity input that is sampled when signal integration ends. The deintegrate count becomes the conversion result. A missing crossing saturates the count and raises an overrange flag. On the last count of every frame a done output is high, and the result register loads the frame's value unless the hold input is high.

Top module: `dslope_seq`

## Requirements
- R1: The frame position advances once every DIV oscillator cycles (default 32). With default parameters, the integrate enable first rises on the 608th oscillator edge after reset is released.
- R2: While the synchronous active-high reset is high, the auto-zero enable is 1, the other enables are 0, done is 0 and the result count, sign and overrange outputs are 0.
- R3: Exactly one of `sw_az`, `sw_int`, `sw_dp`, `sw_dn` is 1 in every cycle.
- R4: Auto-zero occupies frame counts 0 to AZ_MIN-1 (0..18). Integrate occupies exactly the next SI_LEN counts (19..38).
- R5: The `pol_neg` value at the end of the last integrate count selects the direction. With 1, `sw_dn` is enabled for the deintegrate phase; with 0, `sw_dp` is enabled. The direction does not change within the phase.
- R6: Deintegrate starts at count 39. When `cmp_cross` is 1 at the end of deintegrate count j (j = 0..40), the result is j and auto-zero resumes at the next count.
- R7: If no crossing is seen by the end of count 79, the result count is RI_MAX (41) and `res_ovr` is 1. Otherwise `res_ovr` is 0.
- R8: A frame is always 80 counts. `conv_done` is 1 exactly during count 79.
- R9: At the end of count 79 the outputs `res_count`, `res_ovr` and `res_sign` load the frame's result, with the sign set to the sampled polarity. While `hold` is 1 at that point they keep their previous values. They change at no other time.
- R10: `cmp_cross` has no effect outside the deintegrate phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_cross | input | 1 | Comparator reports the integrator has returned to zero |
| pol_neg | input | 1 | Input polarity, 1 = negative |
| hold | input | 1 | Keep the previous result at frame end |
| sw_az | output | 1 | Auto-zero switch enable |
| sw_int | output | 1 | Signal integrate switch enable |
| sw_dp | output | 1 | Deintegrate against positive reference |
| sw_dn | output | 1 | Deintegrate against negative reference |
| conv_done | output | 1 | High during the last count of the frame |
| res_count | output | 6 | Latched deintegrate count |
| res_sign | output | 1 | Latched polarity, 1 = negative |
| res_ovr | output | 1 | Latched overrange flag |

## Verification
In every cycle the assertions check that the enables are one-hot and that each phase stays inside its count window. They also check that a crossing ends deintegration at the next count, that the frame position moves only on a tick, and that the result register changes only at a frame end without hold. Only the bench scenarios can show the exact result values: the crossing count for each programmed crossing point, overrange saturation, a result kept through a held frame, and a sign taken from the sampled polarity. The bench also drives comparator noise during auto-zero and integrate and shows it has no effect on the value.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    localparam int DIV_DEF    = 32;
    localparam int AZ_MIN_DEF = 19;
    localparam int SI_LEN_DEF = 20;
    localparam int RI_MAX_DEF = 41;
    localparam int CNT_W      = $clog2(RI_MAX_DEF + 1);

    typedef enum logic [1:0] {
        PH_AZ = 2'd0,
        PH_SI = 2'd1,
        PH_RI = 2'd2
    } phase_e;

    typedef struct packed {
        logic az;
        logic si;
        logic dp;
        logic dn;
    } sw_t;

    typedef struct packed {
        logic             neg;
        logic             ovr;
        logic [CNT_W-1:0] cnt;
    } result_t;

    function automatic sw_t phase_sw(phase_e ph, logic neg);
        sw_t s;
        s = '0;
        case (ph)
            PH_AZ:   s.az = 1'b1;
            PH_SI:   s.si = 1'b1;
            default: begin
                s.dp = ~neg;
                s.dn = neg;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dslope_prescale.sv
module dslope_prescale #(
    parameter int DIV = 32
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] TOP = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == TOP);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1

endmodule

// File: rtl/dslope_phase_ctrl.sv
module dslope_phase_ctrl
    import dslope_pkg::*;
#(
    parameter int AZ_MIN = 19,
    parameter int SI_LEN = 20,
    parameter int RI_MAX = 41
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    tick,
    input  logic    cmp_cross,
    input  logic    pol_neg,
    output sw_t     sw,
    output logic    last_slot,
    output result_t frame_res
);
    localparam int FRAME  = AZ_MIN + SI_LEN + RI_MAX;
    localparam int SLOT_W = $clog2(FRAME);
    localparam logic [SLOT_W-1:0] S_AZ_END = SLOT_W'(AZ_MIN - 1);
    localparam logic [SLOT_W-1:0] S_SI_BEG = SLOT_W'(AZ_MIN);
    localparam logic [SLOT_W-1:0] S_SI_END = SLOT_W'(AZ_MIN + SI_LEN - 1);
    localparam logic [SLOT_W-1:0] S_RI_BEG = SLOT_W'(AZ_MIN + SI_LEN);
    localparam logic [SLOT_W-1:0] S_LAST   = SLOT_W'(FRAME - 1);
    localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(RI_MAX);

    logic [SLOT_W-1:0] slot;
    phase_e            phase;
    logic [CNT_W-1:0]  ri_cnt;
    logic              neg_q;
    result_t           pend;

    assign last_slot = (slot == S_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            phase  <= PH_AZ;
            ri_cnt <= '0;
            neg_q  <= 1'b0;
            pend   <= '0;
        end else if (tick) begin
            slot <= last_slot ? '0 : slot + 1'b1;
            case (phase)
                PH_AZ: begin
                    if (slot == S_AZ_END)
                        phase <= PH_SI;
                end
                PH_SI: begin
                    if (slot == S_SI_END) begin
                        phase  <= PH_RI;
                        ri_cnt <= '0;
                        neg_q  <= pol_neg;
                    end
                end
                default: begin
                    if (cmp_cross) begin
                        phase <= PH_AZ;
                        pend  <= '{neg: neg_q, ovr: 1'b0, cnt: ri_cnt};
                    end else if (last_slot) begin
                        phase <= PH_AZ;
                        pend  <= '{neg: neg_q, ovr: 1'b1, cnt: CNT_SAT};
                    end else begin
                        ri_cnt <= ri_cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    // value the frame ends with, including a decision taken on the final count
    always_comb begin
        if (phase == PH_RI) begin
            if (cmp_cross)
                frame_res = '{neg: neg_q, ovr: 1'b0, cnt: ri_cnt};
            else
                frame_res = '{neg: neg_q, ovr: 1'b1, cnt: CNT_SAT};
        end else begin
            frame_res = pend;
        end
    end

    assign sw = phase_sw(phase, neg_q);

    AST_ONE_SWITCH: assert property (@(posedge clk) disable iff (rst)
        $countones(sw) == 1); // R3
    AST_SLOT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(slot)); // R1
    AST_AZ_OPENING: assert property (@(posedge clk) disable iff (rst)
        (slot < S_SI_BEG) |-> sw.az); // R4
    AST_SI_WINDOW: assert property (@(posedge clk) disable iff (rst)
        sw.si |-> (slot >= S_SI_BEG && slot <= S_SI_END)); // R4
    AST_SI_TO_RI: assert property (@(posedge clk) disable iff (rst)
        (tick && sw.si && slot == S_SI_END) |=> (sw.dp || sw.dn)); // R5
    AST_DIR_FIXED: assert property (@(posedge clk) disable iff (rst)
        sw.dp |=> !sw.dn); // R5
    AST_RI_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (sw.dp || sw.dn) |-> (slot >= S_RI_BEG)); // R6
    AST_CROSS_ENDS_RI: assert property (@(posedge clk) disable iff (rst)
        (tick && (sw.dp || sw.dn) && cmp_cross) |=> sw.az); // R6
    AST_NOISE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (tick && sw.az && cmp_cross && slot != S_AZ_END) |=> sw.az); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tick && last_slot) |=> !last_slot); // R8

endmodule

// File: rtl/dslope_result_reg.sv
module dslope_result_reg
    import dslope_pkg::*;
#(
    parameter int RI_MAX = 41
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    frame_end,
    input  logic    hold,
    input  result_t res_in,
    output result_t res_q
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(RI_MAX);

    always_ff @(posedge clk) begin
        if (rst)
            res_q <= '0;
        else if (frame_end && !hold)
            res_q <= res_in;
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (frame_end && hold) |=> $stable(res_q)); // R9
    AST_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(res_q)); // R9
    AST_OVR_SATURATES: assert property (@(posedge clk) disable iff (rst)
        res_q.ovr |-> (res_q.cnt == CNT_SAT)); // R7
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        res_q.cnt <= CNT_SAT); // R6

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int DIV    = DIV_DEF,
    parameter int AZ_MIN = AZ_MIN_DEF,
    parameter int SI_LEN = SI_LEN_DEF,
    parameter int RI_MAX = RI_MAX_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmp_cross,
    input  logic             pol_neg,
    input  logic             hold,
    output logic             sw_az,
    output logic             sw_int,
    output logic             sw_dp,
    output logic             sw_dn,
    output logic             conv_done,
    output logic [CNT_W-1:0] res_count,
    output logic             res_sign,
    output logic             res_ovr
);
    logic    tick;
    logic    last_slot;
    sw_t     sw;
    result_t frame_res;
    result_t res_q;

    dslope_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dslope_phase_ctrl #(
        .AZ_MIN (AZ_MIN),
        .SI_LEN (SI_LEN),
        .RI_MAX (RI_MAX)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .cmp_cross (cmp_cross),
        .pol_neg   (pol_neg),
        .sw        (sw),
        .last_slot (last_slot),
        .frame_res (frame_res)
    );

    dslope_result_reg #(.RI_MAX(RI_MAX)) u_res (
        .clk       (clk),
        .rst       (rst),
        .frame_end (tick && last_slot),
        .hold      (hold),
        .res_in    (frame_res),
        .res_q     (res_q)
    );

    assign sw_az     = sw.az;
    assign sw_int    = sw.si;
    assign sw_dp     = sw.dp;
    assign sw_dn     = sw.dn;
    assign conv_done = last_slot;
    assign res_count = res_q.cnt;
    assign res_sign  = res_q.neg;
    assign res_ovr   = res_q.ovr;

endmodule

// File: tb/sim_dslope_seq.sv
`timescale 1ns/1ps
module sim_dslope_seq;
    localparam int DIV = 32, AZ_MIN = 19, SI_LEN = 20, RI_MAX = 41;
    localparam int FRAME = AZ_MIN + SI_LEN + RI_MAX;
    localparam int NFR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_cross = 1'b0, pol_neg = 1'b0, hold = 1'b0;
    logic sw_az, sw_int, sw_dp, sw_dn, conv_done, res_sign, res_ovr;
    logic [5:0] res_count;

    always #5 clk = ~clk;

    dslope_seq u0 (
        .clk(clk), .rst(rst), .cmp_cross(cmp_cross), .pol_neg(pol_neg), .hold(hold),
        .sw_az(sw_az), .sw_int(sw_int), .sw_dp(sw_dp), .sw_dn(sw_dn),
        .conv_done(conv_done), .res_count(res_count), .res_sign(res_sign), .res_ovr(res_ovr)
    );

    // per-frame stimulus: crossing count (-1 = never), polarity, hold, comparator noise
    int prog [NFR] = '{7, 0, 40, -1, 12, 25, 3, 41};
    bit pl   [NFR] = '{0, 1, 0, 1, 0, 1, 0, 0};
    bit hd   [NFR] = '{0, 0, 0, 0, 1, 0, 0, 0};
    bit nz   [NFR] = '{0, 0, 0, 0, 0, 1, 0, 0};

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference model
    int m_pre, m_slot, m_ph, m_n, m_ps;
    int f_cnt, f_ovr, f_sg, o_cnt, o_ovr, o_sg;
    int fr, ncyc;

    always @(posedge clk) begin
        if (rst) begin
            m_pre = 0; m_slot = 0; m_ph = 0; m_n = 0; m_ps = 0;
            f_cnt = 0; f_ovr = 0; f_sg = 0; o_cnt = 0; o_ovr = 0; o_sg = 0;
            fr = 0; ncyc = 0;
        end else begin
            bit tk, last;
            ncyc++;
            tk = (m_pre == DIV - 1);
            m_pre = tk ? 0 : m_pre + 1;
            if (tk) begin
                last = (m_slot == FRAME - 1);
                if (m_ph == 2) begin
                    if (cmp_cross) begin
                        f_cnt = m_n; f_ovr = 0; f_sg = m_ps; m_ph = 0;
                    end else if (last) begin
                        f_cnt = RI_MAX; f_ovr = 1; f_sg = m_ps; m_ph = 0;
                    end else m_n++;
                end else if (m_ph == 0 && m_slot == AZ_MIN - 1) m_ph = 1;
                else if (m_ph == 1 && m_slot == AZ_MIN + SI_LEN - 1) begin
                    m_ph = 2; m_n = 0; m_ps = pol_neg;
                end
                if (last) begin
                    if (!hold) begin o_cnt = f_cnt; o_ovr = f_ovr; o_sg = f_sg; end
                    fr++;
                end
                m_slot = last ? 0 : m_slot + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    int seen_fr = 0;
    bit int_seen = 0;
    int e_cnt = 0, e_ovr = 0, e_sg = 0;

    always @(negedge clk) begin
        if (!rst && !finished) begin
            int idx;
            // cycle-by-cycle comparison against the model
            chk(($countones({sw_az, sw_int, sw_dp, sw_dn}) == 1), "R3 one enable",
                $countones({sw_az, sw_int, sw_dp, sw_dn}), 1);
            chk(sw_az == (m_ph == 0) && sw_int == (m_ph == 1), "R4 az/int enables",
                {sw_az, sw_int}, {(m_ph == 0), (m_ph == 1)});
            chk(sw_dp == (m_ph == 2 && m_ps == 0) && sw_dn == (m_ph == 2 && m_ps == 1),
                "R5 deint direction", {sw_dp, sw_dn}, {(m_ph == 2 && m_ps == 0), (m_ph == 2 && m_ps == 1)});
            chk(conv_done == (m_slot == FRAME - 1), "R8 done", conv_done, (m_slot == FRAME - 1));
            chk(res_count == o_cnt, "R6 result count", res_count, o_cnt);
            chk(res_ovr == o_ovr, "R7 overrange", res_ovr, o_ovr);
            chk(res_sign == o_sg, "R9 sign", res_sign, o_sg);
            // R1: first integrate enable after 19 prescaled counts
            if (sw_int && !int_seen) begin
                int_seen = 1;
                chk(ncyc == AZ_MIN * DIV, "R1 first integrate edge", ncyc, AZ_MIN * DIV);
            end
            // frame-end checks computed from the scenario table only
            if (fr != seen_fr) begin
                int f;
                f = seen_fr;
                seen_fr = fr;
                if (!hd[f]) begin
                    e_ovr = (prog[f] < 0 || prog[f] > RI_MAX - 1);
                    e_cnt = e_ovr ? RI_MAX : prog[f];
                    e_sg  = pl[f];
                end
                if (hd[f])
                    chk(res_count == e_cnt && res_ovr == e_ovr && res_sign == e_sg,
                        "R9 hold keeps result", res_count, e_cnt);
                else if (nz[f])
                    chk(res_count == e_cnt && res_ovr == e_ovr, "R10 noise ignored", res_count, e_cnt);
                else if (e_ovr)
                    chk(res_count == RI_MAX && res_ovr == 1, "R7 saturation", res_count, RI_MAX);
                else
                    chk(res_count == e_cnt && res_ovr == 0, "R6 crossing count", res_count, e_cnt);
                chk(res_sign == e_sg, "R9 frame sign", res_sign, e_sg);
            end
            // comparator stub and input drive for the next edge
            idx = (fr < NFR) ? fr : NFR - 1;
            if (m_ph == 2)
                cmp_cross <= (prog[idx] >= 0) && (m_n >= prog[idx]);
            else
                cmp_cross <= nz[idx];
            pol_neg <= pl[idx];
            hold    <= hd[idx];
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(sw_az && !sw_int && !sw_dp && !sw_dn, "R2 reset enables",
            {sw_az, sw_int, sw_dp, sw_dn}, 4'b1000);
        chk(!conv_done && res_count == 0 && !res_sign && !res_ovr, "R2 reset outputs",
            {conv_done, res_count, res_sign, res_ovr}, 0);
        rst = 1'b0;
        wait (fr == NFR);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", fr, NFR);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule